// File: doc/BRIEF.md
# SPI Master with Sequenced Chip Selects

This block is an SPI master that drives its own slave-select lines, so software never has to toggle a general-purpose pin around a transfer. The host hands it bytes over a valid/ready handshake. With each byte it also gives a slave index, a framing mode and three timing counts. The block turns the slave index into one of several active-low select lines. That line is qualified by an internal frame-enable. The block then shifts the byte out MSB-first in SPI mode 0 while it captures the returning byte.

Around every frame the block inserts three delays, each counted in bit times: a setup delay before the first clock edge, a hold delay after the last one, and a minimum deasserted gap before the next frame. One bit time is one full SCLK period. The SCLK period is set by an even divider of the system clock. In per-word mode every byte gets its own frame. In per-message mode the select stays low over consecutive bytes until a byte flagged as last has been shifted.

Top module: `spi_cs_master`

## Requirements
- R1: After reset all select lines are high, sclk is low, rx_done is low and tx_ready is high.
- R2: cs_n bit i goes low only when slv_sel equals i at the accepted byte that opens the frame. At most one select line is low at any time.
- R3: SPI mode 0, MSB first. sclk idles low and the rising edge comes first. mosi changes only while sclk is low. The slave sees the 8 bits of tx_data on the 8 rising edges. The bits of miso sampled on those rising edges appear in rx_data, MSB first.
- R4: Each shifted byte produces exactly one rx_done pulse, one system clock long, with rx_data valid in that cycle.
- R5: sclk stays high for D system clocks and low for D clocks in each bit. D is clk_div, and D is 1 when clk_div is 0. One bit time is 2*D clocks.
- R6: From a select line falling to the first sclk rise there are (2*S+1)*D system clocks, where S is setup_bt.
- R7: From the last sclk fall of a frame to the select line rising there are 2*H*D system clocks, where H is hold_bt.
- R8: The select stays high for at least 2*G*D clocks between frames, where G is gap_bt. When the next byte is already waiting, the select stays high for exactly 2*G*D+1 clocks.
- R9: With msg_mode=0 (per-word), the select is released after every byte whatever tx_last says.
- R10: With msg_mode=1 (per-message), the select stays low across bytes until a byte with tx_last=1 has been shifted. tx_ready is high between those bytes. A slv_sel change inside an open frame is ignored.
- R11: A setup_bt, hold_bt or gap_bt of 0 behaves as 1.
- R12: sclk is never high while all select lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DW | sclk half period in system clocks (0 acts as 1) |
| setup_bt | input | CW | Setup delay in bit times |
| hold_bt | input | CW | Hold delay in bit times |
| gap_bt | input | CW | Minimum deasserted gap in bit times |
| msg_mode | input | 1 | 0 = frame per byte, 1 = frame per message |
| slv_sel | input | AW | Slave index, taken when a frame opens |
| tx_valid | input | 1 | A byte is offered |
| tx_data | input | 8 | Byte to send |
| tx_last | input | 1 | Byte closes the message (per-message mode) |
| tx_ready | output | 1 | Block takes the offered byte at this edge |
| rx_data | output | 8 | Received byte |
| rx_done | output | 1 | One-clock pulse, rx_data valid |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NSLV | Active-low slave selects |

## Verification
A select line falls on the clock after a byte is accepted. The first sclk rise follows (2*S+1)*D clocks later. sclk toggles every D clocks after that, and rx_done rises together with the 16th toggle. The select rises 2*H*D clocks after the last fall. With a byte already waiting, it falls again 2*G*D+1 clocks later. A monitor samples every port on the falling system-clock edge and counts these intervals in whole clocks. Each directed task compares the counts against values it computes from its own settings. A slave model in the bench drives miso and captures mosi on the sclk edges, so the data checks never depend on process order at a clock edge.

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int NSLV = 4,
  parameter int CW   = 8,
  parameter int DW   = 8,
  localparam int AW  = (NSLV > 1) ? $clog2(NSLV) : 1,
  localparam int TW  = CW + DW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   clk_div,
  input  logic [CW-1:0]   setup_bt,
  input  logic [CW-1:0]   hold_bt,
  input  logic [CW-1:0]   gap_bt,
  input  logic            msg_mode,
  input  logic [AW-1:0]   slv_sel,
  input  logic            tx_valid,
  input  logic [7:0]      tx_data,
  input  logic            tx_last,
  output logic            tx_ready,
  output logic [7:0]      rx_data,
  output logic            rx_done,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NSLV-1:0] cs_n
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_WAIT, S_HOLD, S_GAP} st_t;

  st_t           st;
  logic [TW-1:0] tm;
  logic [DW-1:0] hc;
  logic [4:0]    tg;
  logic [7:0]    txs, rxs;
  logic [AW-1:0] addr_q;
  logic          fen, mode_q, last_q;

  wire [DW-1:0] half = (clk_div == '0) ? DW'(1) : clk_div;

  function automatic logic [TW-1:0] span(input logic [CW-1:0] n, input logic [DW-1:0] h);
    logic [CW-1:0] m;
    m = (n == '0) ? CW'(1) : n;
    return (TW'(m) * TW'(h) * TW'(2)) - TW'(1);
  endfunction

  assign tx_ready = (st == S_IDLE) || (st == S_WAIT);
  assign mosi     = txs[7];

  for (genvar i = 0; i < NSLV; i++) begin : g_sel
    assign cs_n[i] = ~(fen && (addr_q == AW'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tm <= '0; hc <= '0; tg <= '0;
      txs <= '0; rxs <= '0; rx_data <= '0; rx_done <= 1'b0;
      sclk <= 1'b0; fen <= 1'b0; addr_q <= '0; mode_q <= 1'b0; last_q <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      case (st)
        S_IDLE: if (tx_valid) begin
          addr_q <= slv_sel; mode_q <= msg_mode; last_q <= tx_last;
          txs <= tx_data; fen <= 1'b1;
          tm <= span(setup_bt, half); st <= S_SETUP;
        end
        S_SETUP: if (tm == '0) begin
          st <= S_SHIFT; hc <= half - DW'(1); tg <= '0;
        end else tm <= tm - TW'(1);
        S_SHIFT: if (hc == '0) begin
          hc <= half - DW'(1);
          sclk <= ~sclk;
          tg <= tg + 5'd1;
          if (!sclk) rxs <= {rxs[6:0], miso};
          else       txs <= {txs[6:0], 1'b0};
          if (tg == 5'd15) begin
            rx_done <= 1'b1;
            rx_data <= rxs;
            if (!mode_q || last_q) begin
              st <= S_HOLD; tm <= span(hold_bt, half);
            end else st <= S_WAIT;
          end
        end else hc <= hc - DW'(1);
        S_WAIT: if (tx_valid) begin
          txs <= tx_data; last_q <= tx_last;
          st <= S_SHIFT; hc <= half - DW'(1); tg <= '0;
        end
        S_HOLD: if (tm == '0) begin
          fen <= 1'b0; tm <= span(gap_bt, half); st <= S_GAP;
        end else tm <= tm - TW'(1);
        S_GAP: if (tm == '0) st <= S_IDLE;
          else tm <= tm - TW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk #(
  parameter int NSLV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSLV-1:0] cs_n,
  input logic            sclk,
  input logic            mosi,
  input logic            rx_done
);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R2

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk); // R12

  AST_MOSI_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R4

  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cs_n) != '0 && $past((~cs_n) != '0)) |-> (cs_n == $past(cs_n))); // R10

endmodule

bind spi_cs_master spi_cs_master_chk #(.NSLV(NSLV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .rx_done(rx_done)
);

// File: tb/tb_spi_cs_master.sv
module tb_spi_cs_master;
  localparam int NSLV = 4;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int AW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] clk_div = '0;
  logic [CW-1:0] setup_bt = '0, hold_bt = '0, gap_bt = '0;
  logic msg_mode = 1'b0, tx_valid = 1'b0, tx_last = 1'b0;
  logic [AW-1:0] slv_sel = '0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_done, sclk, mosi, miso;
  logic [7:0] rx_data;
  logic [NSLV-1:0] cs_n;

  always #4 clk = ~clk;

  spi_cs_master #(.NSLV(NSLV), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .setup_bt(setup_bt),
    .hold_bt(hold_bt), .gap_bt(gap_bt), .msg_mode(msg_mode), .slv_sel(slv_sel),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_done(rx_done), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n));

  int vectors = 0, errs = 0;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 60) & 255);
  endfunction

  // slave model
  int widx = 0;
  logic [2:0] scnt = '0;
  logic [7:0] cur;
  assign cur  = pat(widx);
  assign miso = cur[~scnt];
  always @(negedge sclk) if (rst_n) begin
    if (scnt == 3'd7) widx++;
    scnt <= scnt + 3'd1;
  end
  logic [7:0] mcap = '0;
  int mbits = 0;
  logic [7:0] sg_log [0:63];
  int sg_n = 0;
  always @(posedge sclk) if (rst_n) begin
    mcap = {mcap[6:0], mosi};
    mbits++;
    if (mbits == 8) begin sg_log[sg_n] = mcap; sg_n++; mbits = 0; end
  end

  // interval monitor
  logic [7:0] rx_log [0:63];
  int rx_n = 0;
  int setup_cnt = 0, last_setup = 0, lo_cnt = 0, last_hold = 0;
  int hi_cnt = 0, last_gap = 0, shi = 0, last_shi = 0, cs_falls = 0, sclk_bad = 0;
  bit seen_rise = 0, prev_low = 0, prev_sclk = 0;
  logic [NSLV-1:0] low_mask = '0;
  always @(negedge clk) if (rst_n) begin
    if (rx_done) begin rx_log[rx_n] = rx_data; rx_n++; end
    if (&cs_n && sclk) sclk_bad++;
    low_mask |= ~cs_n;
    if (!(&cs_n)) begin
      if (!prev_low) begin cs_falls++; last_gap = hi_cnt; hi_cnt = 0; end
      if (!seen_rise) begin
        if (sclk) begin last_setup = setup_cnt; seen_rise = 1; end
        else setup_cnt++;
      end
      if (sclk) lo_cnt = 0; else lo_cnt++;
    end else begin
      if (prev_low) last_hold = lo_cnt;
      hi_cnt++; setup_cnt = 0; seen_rise = 0; lo_cnt = 0;
    end
    if (sclk) shi++;
    else if (prev_sclk) begin last_shi = shi; shi = 0; end
    prev_low = !(&cs_n);
    prev_sclk = sclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [7:0] sent [0:63];
  int sent_n = 0;

  task automatic cfg(input int d, input int s, input int h, input int g, input bit m);
    clk_div = DW'(d); setup_bt = CW'(s); hold_bt = CW'(h); gap_bt = CW'(g); msg_mode = m;
  endtask

  task automatic put(input int a, input logic [7:0] d, input bit last);
    tx_valid = 1'b1; slv_sel = AW'(a); tx_data = d; tx_last = last;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    sent[sent_n] = d; sent_n++;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(tx_ready && (&cs_n))) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_words(input int first, input int n);
    chk("R4 rx_done pulse count", rx_n, first + n);
    for (int i = first; i < first + n; i++) begin
      chk("R3 rx_data from miso", int'(rx_log[i]), int'(pat(i)));
      chk("R3 mosi byte at slave", int'(sg_log[i]), int'(sent[i]));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cs_n at reset", int'(cs_n), 15);
    chk("R1 sclk at reset", int'(sclk), 0);
    chk("R1 rx_done at reset", int'(rx_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_ready after reset", int'(tx_ready), 1);
    chk("R1 cs_n after reset", int'(cs_n), 15);
  endtask

  task automatic t_per_word();
    int f0 = cs_falls, r0 = rx_n;
    cfg(2, 1, 1, 1, 0);
    low_mask = '0;
    put(2, 8'hC3, 0);
    put(2, 8'h5A, 0);
    wait_idle();
    chk("R9 one frame per word", cs_falls - f0, 2);
    chk("R2 only slave 2 selected", int'(low_mask), 4);
    chk("R8 gap 2*G*D+1", last_gap, 5);
    chk("R6 setup (2S+1)*D", last_setup, 6);
    check_words(r0, 2);
  endtask

  task automatic t_timing();
    int r0 = rx_n;
    cfg(3, 2, 3, 2, 0);
    put(1, 8'h81, 1);
    put(1, 8'h7E, 1);
    wait_idle();
    chk("R6 setup (2S+1)*D", last_setup, 15);
    chk("R7 hold 2*H*D", last_hold, 18);
    chk("R8 gap 2*G*D+1", last_gap, 13);
    chk("R5 sclk high D", last_shi, 3);
    check_words(r0, 2);
  endtask

  task automatic t_clamp();
    int r0 = rx_n;
    cfg(0, 0, 0, 0, 0);
    put(0, 8'hF0, 1);
    put(0, 8'h0F, 0);
    wait_idle();
    chk("R11 setup clamp", last_setup, 3);
    chk("R11 hold clamp", last_hold, 2);
    chk("R11 gap clamp", last_gap, 3);
    chk("R5 divider 0 acts as 1", last_shi, 1);
    check_words(r0, 2);
  endtask

  task automatic t_message();
    int f0 = cs_falls, r0 = rx_n;
    cfg(2, 1, 2, 1, 1);
    low_mask = '0;
    put(3, 8'hA6, 0);
    put(0, 8'h19, 0);
    put(2, 8'hE2, 1);
    wait_idle();
    chk("R10 one frame for message", cs_falls - f0, 1);
    chk("R10 address change ignored", int'(low_mask), 8);
    chk("R7 hold after last word", last_hold, 8);
    check_words(r0, 3);
  endtask

  task automatic t_each_addr();
    for (int a = 0; a < NSLV; a++) begin
      cfg(1, 1, 1, 1, 0);
      low_mask = '0;
      put(a, 8'(a * 17 + 3), 1);
      wait_idle();
      chk("R2 decoded select", int'(low_mask), 1 << a);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; vectors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_per_word();
    t_timing();
    t_clamp();
    t_message();
    t_each_addr();
    chk("R12 sclk idle while deselected", sclk_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule